// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block decides which of two input clocks reaches a bank of ten outputs, and which of those outputs carry it. It has one configuration clock, a single serial pin, and a mode pin. In program mode the serial pin feeds an 11-bit shift register, one bit per configuration clock edge. The edge after the eleventh commits the word to a control register. That register holds ten output enables and a select for the input clock. Once committed, the word is frozen until the block is reset. Until then, every output is held low.

In standard mode the control register is bypassed. All ten outputs carry a clock, and the level on the serial pin picks the input clock directly. Any configuration clock edge taken in standard mode resets the loader, the shift register and the control register. The next programming pass therefore starts from a clean state.

Each output is the selected input clock ANDed with that output's enable. All signals are single-ended. The enables are registered on the configuration clock and are not synchronised to the input clocks.

Top module: `fanout_clk_ctrl`

## Requirements
- R1: A configuration clock edge with `rst` high clears the loader and the control register. Afterwards `cfg_locked` is 0, and with `prog_en` high every `clk_out` bit is 0. This also holds when the reset lands part-way through a load.
- R2: A configuration clock edge with `prog_en` low clears the loader and the control register. When `prog_en` then returns high, `cfg_locked` is 0, all outputs are 0, and a fresh 12-clock sequence programs a new word.
- R3: While `prog_en` is low, all ten outputs are enabled and the committed word has no effect. `ser_in` = 0 routes `clk_in0` to every output, and `ser_in` = 1 routes `clk_in1`.
- R4: In program mode, before a commit, every output is 0 and `cfg_locked` is 0. This includes the cycle after exactly 11 shifting edges.
- R5: The twelfth program-mode edge after a reset commits the shift register contents, and `cfg_locked` reads 1 after that edge.
- R6: The serial order is fixed. The first bit is the enable for output 9, the second is the enable for output 8, and so on, so the tenth bit is the enable for output 0. The eleventh bit is the clock select: 0 picks `clk_in0` and 1 picks `clk_in1`.
- R7: In program mode after a commit, an output whose enable bit is 1 equals the selected input clock, and an output whose enable bit is 0 is constant 0.
- R8: After a commit, further program-mode edges do not change the enables or the select, whatever `ser_in` does, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | 1 = program mode, 0 = standard mode and clocked reset |
| ser_in | input | 1 | Serial configuration data; direct clock select in standard mode |
| clk_in0 | input | 1 | Input clock 0 |
| clk_in1 | input | 1 | Input clock 1 |
| clk_out | output | 10 | Gated fanout outputs, index = output number |
| cfg_locked | output | 1 | High once a word has been committed |

## Verification
Two situations are the hardest to reach from the ports. The first is the edge between the eleventh shift and the commit, where a one-off error in the bit counter would expose outputs one cycle early. The second is a reset that arrives in the middle of a load, where a stale count would commit a half-loaded word. The stimulus checks the outputs after exactly eleven edges and again after the twelfth. It also abandons a load after five bits with `rst` and then reprograms with a different word. The input clocks are driven as static levels in several combinations, so each output's enable and the select can be read directly at `clk_out`.

// File: rtl/fanout_cfg_pkg.sv
package fanout_cfg_pkg;
  // Loader progress: collecting bits, word complete, word committed.
  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } load_state_e;
endpackage

// File: rtl/fanout_loader.sv
module fanout_loader
  import fanout_cfg_pkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              ser_in,
  output logic [WORD_W-1:0] shift_word,
  output logic              commit
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  load_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] sr_q;

  // The serial bit enters at the top stage and moves downward each edge.
  always_ff @(posedge clk) begin
    if (rst || !prog_en) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else begin
      case (state_q)
        ST_LOAD: begin
          sr_q  <= {ser_in, sr_q[WORD_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) state_q <= ST_ARMED;
        end
        ST_ARMED:  state_q <= ST_LOCKED;
        ST_LOCKED: state_q <= ST_LOCKED;
        default:   state_q <= ST_LOAD;
      endcase
    end
  end

  assign shift_word = sr_q;
  assign commit     = prog_en && (state_q == ST_ARMED);
endmodule

// File: rtl/fanout_ctrl_reg.sv
module fanout_ctrl_reg #(
  parameter int N_OUT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_en,
  input  logic             commit,
  input  logic [N_OUT:0]   word_in,
  output logic [N_OUT-1:0] en_q,
  output logic             sel_q,
  output logic             locked_q
);
  logic [N_OUT-1:0] en_map;

  // Word bit (N_OUT-1-i) holds the enable for output i; the top bit is the select.
  for (genvar i = 0; i < N_OUT; i++) begin : g_map
    assign en_map[i] = word_in[N_OUT-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst || !prog_en) begin
      en_q     <= '0;
      sel_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (commit && !locked_q) begin
      en_q     <= en_map;
      sel_q    <= word_in[N_OUT];
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fanout_gate.sv
module fanout_gate #(
  parameter int N_OUT = 10
) (
  input  logic             prog_en,
  input  logic             ser_in,
  input  logic             locked,
  input  logic [N_OUT-1:0] en_q,
  input  logic             sel_q,
  input  logic             clk_in0,
  input  logic             clk_in1,
  output logic [N_OUT-1:0] clk_out
);
  logic [N_OUT-1:0] eff_en;
  logic             eff_sel;
  logic             src_clk;

  always_comb begin
    if (!prog_en) begin
      eff_en  = '1;
      eff_sel = ser_in;
    end else begin
      eff_en  = locked ? en_q : '0;
      eff_sel = sel_q;
    end
  end

  assign src_clk = eff_sel ? clk_in1 : clk_in0;

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    assign clk_out[i] = src_clk & eff_en[i];
  end
endmodule

// File: rtl/fanout_clk_ctrl.sv
module fanout_clk_ctrl #(
  parameter int N_OUT = 10
) (
  input  logic             cfg_clk,
  input  logic             rst,
  input  logic             prog_en,
  input  logic             ser_in,
  input  logic             clk_in0,
  input  logic             clk_in1,
  output logic [N_OUT-1:0] clk_out,
  output logic             cfg_locked
);
  localparam int WORD_W = N_OUT + 1;

  logic [WORD_W-1:0] shift_word;
  logic              commit;
  logic [N_OUT-1:0]  en_q;
  logic              sel_q;

  fanout_loader #(.WORD_W(WORD_W)) u_loader (
    .clk        (cfg_clk),
    .rst        (rst),
    .prog_en    (prog_en),
    .ser_in     (ser_in),
    .shift_word (shift_word),
    .commit     (commit)
  );

  fanout_ctrl_reg #(.N_OUT(N_OUT)) u_ctrl (
    .clk      (cfg_clk),
    .rst      (rst),
    .prog_en  (prog_en),
    .commit   (commit),
    .word_in  (shift_word),
    .en_q     (en_q),
    .sel_q    (sel_q),
    .locked_q (cfg_locked)
  );

  fanout_gate #(.N_OUT(N_OUT)) u_gate (
    .prog_en (prog_en),
    .ser_in  (ser_in),
    .locked  (cfg_locked),
    .en_q    (en_q),
    .sel_q   (sel_q),
    .clk_in0 (clk_in0),
    .clk_in1 (clk_in1),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/fanout_clk_ctrl_chk.sv
module fanout_clk_ctrl_chk #(
  parameter int N_OUT = 10
) (
  input logic             cfg_clk,
  input logic             rst,
  input logic             prog_en,
  input logic             ser_in,
  input logic             clk_in0,
  input logic             clk_in1,
  input logic [N_OUT-1:0] clk_out,
  input logic             cfg_locked,
  input logic [N_OUT-1:0] ctrl_en,
  input logic             ctrl_sel
);
  p_unlocked_dark_r4: assert property (@(posedge cfg_clk) disable iff (rst)
    (prog_en && !cfg_locked) |-> (clk_out == '0));

  p_std_all_on_r3: assert property (@(posedge cfg_clk) disable iff (rst)
    !prog_en |-> (clk_out == (ser_in ? {N_OUT{clk_in1}} : {N_OUT{clk_in0}})));

  p_std_clears_r2: assert property (@(posedge cfg_clk) disable iff (rst)
    !prog_en |=> !cfg_locked);

  p_lock_hold_r8: assert property (@(posedge cfg_clk) disable iff (rst)
    (prog_en && cfg_locked) |=> (cfg_locked && $stable(ctrl_en) && $stable(ctrl_sel)));

  p_gated_off_r7: assert property (@(posedge cfg_clk) disable iff (rst)
    (prog_en && cfg_locked) |-> ((clk_out & ~ctrl_en) == '0));

  p_commit_in_prog_r5: assert property (@(posedge cfg_clk) disable iff (rst)
    $rose(cfg_locked) |-> $past(prog_en));
endmodule

bind fanout_clk_ctrl fanout_clk_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .cfg_clk    (cfg_clk),
  .rst        (rst),
  .prog_en    (prog_en),
  .ser_in     (ser_in),
  .clk_in0    (clk_in0),
  .clk_in1    (clk_in1),
  .clk_out    (clk_out),
  .cfg_locked (cfg_locked),
  .ctrl_en    (en_q),
  .ctrl_sel   (sel_q)
);

// File: tb/tb_fanout_clk_ctrl.sv
module tb_fanout_clk_ctrl;
  localparam int N = 10;

  logic         cfg_clk = 1'b0;
  logic         rst, prog_en, ser_in, clk_in0, clk_in1;
  logic [N-1:0] clk_out;
  logic         cfg_locked;
  int           n_run = 0;
  int           n_fail = 0;

  always #5 cfg_clk = ~cfg_clk;

  fanout_clk_ctrl #(.N_OUT(N)) dut (
    .cfg_clk(cfg_clk), .rst(rst), .prog_en(prog_en), .ser_in(ser_in),
    .clk_in0(clk_in0), .clk_in1(clk_in1), .clk_out(clk_out), .cfg_locked(cfg_locked)
  );

  // Table entry: {select, enable[9:0]}, where enable index = output number.
  localparam logic [10:0] VEC [7] = '{11'h3FF, 11'h7FF, 11'h000, 11'h401,
                                      11'h200, 11'h555, 11'h2AA};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge cfg_clk);
    #2;
  endtask

  function automatic logic [N-1:0] exp_out(logic [10:0] w, logic c0, logic c1);
    return w[9:0] & {N{(w[10] ? c1 : c0)}};
  endfunction

  // R6: first serial bit = enable of output 9 ... tenth = output 0, eleventh = select.
  task automatic shift_word(input logic [10:0] w);
    for (int k = 0; k < N; k++) begin
      ser_in = w[N-1-k];
      tick();
    end
    ser_in = w[10];
    tick();
  endtask

  // R7: drive static clock levels and read the gated outputs.
  task automatic observe(input string req, input logic [10:0] w);
    for (int c = 1; c < 4; c++) begin
      clk_in0 = c[0];
      clk_in1 = c[1];
      #1;
      chk(req, 32'(clk_out), 32'(exp_out(w, c[0], c[1])));
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; prog_en = 1'b1; ser_in = 1'b0; clk_in0 = 1'b1; clk_in1 = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    chk("R1 reset locked", 32'(cfg_locked), 0);
    chk("R1 reset outputs", 32'(clk_out), 0);

    foreach (VEC[v]) begin
      prog_en = 1'b0; tick();
      prog_en = 1'b1; #1;
      chk("R2 cleared after std edge", 32'(cfg_locked), 0);
      shift_word(VEC[v]);
      clk_in0 = 1'b1; clk_in1 = 1'b1; #1;
      chk("R4 dark after 11 edges", 32'(clk_out), 0);
      chk("R4 unlocked after 11 edges", 32'(cfg_locked), 0);
      ser_in = ~ser_in;
      tick();
      chk("R5 locked after 12th edge", 32'(cfg_locked), 1);
      observe("R6 R7 committed pattern", VEC[v]);
    end

    // R8: last committed word was 11'h2AA; keep clocking with varied data.
    for (int k = 0; k < 6; k++) begin
      ser_in = k[0];
      tick();
    end
    chk("R8 still locked", 32'(cfg_locked), 1);
    observe("R8 word unchanged", 11'h2AA);

    // R3: standard mode routes the pin-selected clock to every output.
    prog_en = 1'b0; ser_in = 1'b0; clk_in0 = 1'b1; clk_in1 = 1'b0; #1;
    chk("R3 std sel0", 32'(clk_out), 32'(10'h3FF));
    ser_in = 1'b1; #1;
    chk("R3 std sel1 low", 32'(clk_out), 0);
    clk_in1 = 1'b1; clk_in0 = 1'b0; #1;
    chk("R3 std sel1 high", 32'(clk_out), 32'(10'h3FF));
    tick();
    chk("R2 std edge unlocks", 32'(cfg_locked), 0);
    prog_en = 1'b1; #1;
    chk("R2 back in program dark", 32'(clk_out), 0);

    // R1: reset during a partial load, then a full new word must land correctly.
    for (int k = 0; k < 5; k++) begin
      ser_in = 1'b1;
      tick();
    end
    rst = 1'b1; tick(); rst = 1'b0; #1;
    chk("R1 mid-load reset dark", 32'(clk_out), 0);
    shift_word(11'h481);
    chk("R1 no early commit", 32'(cfg_locked), 0);
    tick();
    chk("R1 locked after reprogram", 32'(cfg_locked), 1);
    observe("R1 R6 reprogram pattern", 11'h481);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule